// File: doc/BRIEF.md
# Paged Packet Buffer Allocator

This block manages a packet memory divided into 256-byte pages. It does not hold the memory itself. It keeps track of which packet numbers are in use, how many pages each one holds, and how many pages are still free. A host drives it with one-cycle commands: allocate, reset, enqueue, free and release. It reads back the grant result, the interrupt status bits and the number of free pages. The free-page count times 256 gives the free buffer space in bytes. Right after reset it gives the total memory size.

Three FIFOs of packet numbers sit alongside the allocator:
- a transmit queue, which the host fills with enqueue commands and which a MAC transmitter drains with an acknowledge;
- a completion FIFO, which collects packets whose transmission has finished;
- a receive FIFO, which a MAC receiver fills by depositing packets for which the unit picks a number itself.

The control state machine has two states, `ST_IDLE` and `ST_WAIT`:
- `ST_IDLE` → `ST_WAIT` when a host allocate finds a free packet number but too few free pages.
- `ST_WAIT` → `ST_IDLE` when the pending request is granted, or when a reset command arrives.
- An allocate with no free packet number fails at once and stays in `ST_IDLE`.

Top module: `pba_unit`

## Requirements
- R1: After `rst_n` is released: `free_pages` equals TOTAL_PAGES (64 by default), `irq_status` is 0, `alloc_result` is 0, `rx_empty` is 1, and `tx_req` and `cmpl_valid` are 0.
- R2: An allocate command (`cmd_op` = 1) asks for `cmd_arg`+1 pages, so a value of 0 asks for one page. If a packet number and enough pages are free, then at the next clock edge:
  - `alloc_result` holds the granted number in its low bits, with bit 7 = 0;
  - `free_pages` drops by the page count;
  - `irq_status[0]` (allocation done) is set.
- R3: Packet numbers 0 to PKT_NUM-1 (31 by default) are granted lowest-free-first, both to host allocations and to receive deposits.
- R4: An allocate issued while all packet numbers are in use fails at the next edge. `alloc_result` becomes 8'h80 (bit 7 set, other bits 0), `irq_status[0]` is set and `free_pages` is unchanged.
- R5: An allocate that finds a free number but too few free pages stays pending: no interrupt, and `alloc_result` is unchanged. It is granted at the first clock edge at which enough pages are free.
- R6: Writing 1 to a bit of `irq_clr` clears the matching `irq_status` bit. If a set event happens in the same cycle, the set wins.
- R7: An enqueue command (`cmd_op` = 3) appends the packet number held in `pnr_q` to the transmit queue. `tx_req` and `tx_pkt` present the oldest queued number.
- R8: `tx_ack` while `tx_req` is high has three effects at the next edge:
  - the head of the transmit queue is removed;
  - that number is appended to the completion FIFO;
  - `irq_status[1]` (transmit done) is set.
  `cmpl_valid` and `cmpl_pkt` show the oldest completed number, and `cmpl_pop` removes it.
- R9: A free command (`cmd_op` = 4) returns the pages of the packet named in `pnr_q` at the next edge. Freeing a number that is not allocated has no effect.
- R10: A deposit on `rx_valid` is accepted, with `rx_ack` high in the same cycle, only when all of these hold:
  - the unit is in `ST_IDLE`;
  - no allocate or reset command is present in that cycle;
  - a number is free and `rx_npages`+1 pages are free.
  The granted number is appended to the receive FIFO and its pages are taken.
- R11: A release command (`cmd_op` = 5) frees the pages of the packet at the head of the receive FIFO and pops it. While `rx_empty` is 1, a release has no effect.
- R12: A reset command (`cmd_op` = 2) frees every packet, empties all three FIFOs and drops a pending allocation, all at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command code: 0 none, 1 allocate, 2 reset, 3 enqueue, 4 free, 5 release |
| cmd_arg | input | CNT_W | Page count minus one, used by allocate |
| pnr_wr | input | 1 | Loads the packet-number register |
| pnr_wdata | input | log2(PKT_NUM) | New packet-number register value |
| pnr_q | output | log2(PKT_NUM) | Packet-number register |
| irq_clr | input | 2 | Write-1-to-clear for the interrupt status bits |
| irq_status | output | 2 | Bit 0 allocation done, bit 1 transmit done |
| alloc_result | output | 8 | Granted number, or bit 7 set on failure |
| free_pages | output | log2(TOTAL_PAGES+1) | Free pages (each 256 bytes) |
| tx_req | output | 1 | Transmit queue holds a packet |
| tx_pkt | output | log2(PKT_NUM) | Packet at the head of the transmit queue |
| tx_ack | input | 1 | Transmitter finished the head packet |
| cmpl_valid | output | 1 | Completion FIFO not empty |
| cmpl_pkt | output | log2(PKT_NUM) | Oldest completed packet |
| cmpl_pop | input | 1 | Removes the oldest completed packet |
| rx_valid | input | 1 | Receiver requests a buffer for a packet |
| rx_npages | input | CNT_W | Pages needed by the received packet, minus one |
| rx_ack | output | 1 | Deposit accepted this cycle |
| rx_empty | output | 1 | No received packet pending |
| rx_head | output | log2(PKT_NUM) | Oldest received packet number |

## Verification
A table of allocations with the page counts 1, 8, 4, 2 and 7 checks that the granted numbers climb from zero and that the free-page count follows each size. A mismatch there separates an off-by-one page count from a wrong picking order. Freeing a middle packet and allocating again shows that the lowest hole is reused rather than the next number after the last grant. Starving the page pool, and separately filling all 32 numbers, separates the pending path from the fail path. Two packets enqueued in reverse number order, then deposits and releases around an allocate that collides with a deposit, show FIFO order, the arbitration between host and receiver, and release on an empty FIFO.

// File: rtl/pba_pkg.sv
package pba_pkg;
    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ALLOC   = 3'd1,
        OP_RESET   = 3'd2,
        OP_ENQ     = 3'd3,
        OP_FREE    = 3'd4,
        OP_RELEASE = 3'd5
    } pba_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } pba_state_e;
endpackage

// File: rtl/pba_pick.sv
module pba_pick #(
    parameter int N = 32
) (
    input  logic [N-1:0]         busy,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    // Scan from the top down so that the lowest free number is the one kept.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pba_fifo.sv
module pba_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else if (flush) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wp[AW-1:0]] <= din;
    end

    assign dout  = mem[rp[AW-1:0]];
    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);

    // R7: queues are never written beyond capacity
    p_fifo_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |-> !full);
    // R11: nothing is popped from an empty queue
    p_fifo_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |-> !empty);
endmodule

// File: rtl/pba_unit.sv
module pba_unit
    import pba_pkg::*;
#(
    parameter int PKT_NUM     = 32,
    parameter int TOTAL_PAGES = 64,
    parameter int CNT_W       = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cmd_valid,
    input  logic [2:0]                         cmd_op,
    input  logic [CNT_W-1:0]                   cmd_arg,
    input  logic                               pnr_wr,
    input  logic [$clog2(PKT_NUM)-1:0]         pnr_wdata,
    output logic [$clog2(PKT_NUM)-1:0]         pnr_q,
    input  logic [1:0]                         irq_clr,
    output logic [1:0]                         irq_status,
    output logic [7:0]                         alloc_result,
    output logic [$clog2(TOTAL_PAGES+1)-1:0]   free_pages,
    output logic                               tx_req,
    output logic [$clog2(PKT_NUM)-1:0]         tx_pkt,
    input  logic                               tx_ack,
    output logic                               cmpl_valid,
    output logic [$clog2(PKT_NUM)-1:0]         cmpl_pkt,
    input  logic                               cmpl_pop,
    input  logic                               rx_valid,
    input  logic [CNT_W-1:0]                   rx_npages,
    output logic                               rx_ack,
    output logic                               rx_empty,
    output logic [$clog2(PKT_NUM)-1:0]         rx_head
);
    localparam int NUM_W  = $clog2(PKT_NUM);
    localparam int FREE_W = $clog2(TOTAL_PAGES + 1);
    localparam int PG_W   = CNT_W + 1;

    pba_state_e        state_q, state_d;
    logic [PG_W-1:0]   need_q, need_d;
    logic [PKT_NUM-1:0] used_q, used_d;
    logic [PG_W-1:0]   pages_q [PKT_NUM];
    logic [FREE_W-1:0] free_q, free_d;
    logic [1:0]        irq_q;
    logic [7:0]        result_q;

    pba_op_e           op;
    logic              c_alloc, c_reset, c_enq, c_free, c_rel;
    logic [PG_W-1:0]   host_need, rx_need, want, take_pages;
    logic              found, fits, alloc_try, alloc_grant, alloc_fail, grant_any;
    logic [NUM_W-1:0]  pick_idx, drop_idx;
    logic              drop;
    logic              txq_empty, txq_full, cq_empty, cq_full, rxq_full, rel_hit, tx_ok;

    assign op      = pba_op_e'(cmd_op);
    assign c_alloc = cmd_valid && (op == OP_ALLOC);
    assign c_reset = cmd_valid && (op == OP_RESET);
    assign c_enq   = cmd_valid && (op == OP_ENQ);
    assign c_free  = cmd_valid && (op == OP_FREE);
    assign c_rel   = cmd_valid && (op == OP_RELEASE);

    assign host_need = PG_W'(cmd_arg) + 1'b1;
    assign rx_need   = PG_W'(rx_npages) + 1'b1;

    pba_pick #(.N(PKT_NUM)) pick_i (.busy(used_q), .found(found), .idx(pick_idx));

    // Allocation arbitration: a pending request has the allocator to itself;
    // the receiver gets it only in idle with no host allocate or reset.
    always_comb begin
        want        = (state_q == ST_WAIT) ? need_q : host_need;
        fits        = found && (free_q >= FREE_W'(want));
        alloc_try   = (state_q == ST_WAIT) || c_alloc;
        alloc_grant = alloc_try && fits && !c_reset;
        alloc_fail  = (state_q == ST_IDLE) && c_alloc && !found;
        rx_ack      = rx_valid && (state_q == ST_IDLE) && !c_alloc && !c_reset &&
                      found && (free_q >= FREE_W'(rx_need)) && !rxq_full;
        grant_any   = alloc_grant || rx_ack;
        take_pages  = alloc_grant ? want : rx_need;
    end

    // Page return path: free by packet-number register, or release of rx head.
    always_comb begin
        rel_hit  = c_rel && !rx_empty;
        drop_idx = rel_hit ? rx_head : pnr_q;
        drop     = (c_free || rel_hit) && used_q[drop_idx];
    end

    always_comb begin
        used_d = used_q;
        free_d = free_q;
        if (c_reset) begin
            used_d = '0;
            free_d = FREE_W'(TOTAL_PAGES);
        end else begin
            if (drop) begin
                used_d[drop_idx] = 1'b0;
                free_d = free_d + FREE_W'(pages_q[drop_idx]);
            end
            if (grant_any) begin
                used_d[pick_idx] = 1'b1;
                free_d = free_d - FREE_W'(take_pages);
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        need_d  = need_q;
        unique case (state_q)
            ST_IDLE: if (c_alloc && found && !fits) begin
                state_d = ST_WAIT;
                need_d  = host_need;
            end
            ST_WAIT: if (c_reset || alloc_grant) state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            need_q  <= '0;
        end else begin
            state_q <= state_d;
            need_q  <= need_d;
        end
    end

    // Output and bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q   <= '0;
            free_q   <= FREE_W'(TOTAL_PAGES);
            irq_q    <= '0;
            result_q <= '0;
            pnr_q    <= '0;
            for (int i = 0; i < PKT_NUM; i++) pages_q[i] <= '0;
        end else begin
            used_q <= used_d;
            free_q <= free_d;
            if (grant_any) pages_q[pick_idx] <= take_pages;
            if (alloc_grant)     result_q <= 8'(pick_idx);
            else if (alloc_fail) result_q <= 8'h80;
            irq_q[0] <= (alloc_grant || alloc_fail) || (irq_q[0] && !irq_clr[0]);
            irq_q[1] <= tx_ok || (irq_q[1] && !irq_clr[1]);
            if (pnr_wr) pnr_q <= pnr_wdata;
        end
    end

    assign tx_ok = tx_ack && !txq_empty && !cq_full;

    pba_fifo #(.DEPTH(PKT_NUM), .W(NUM_W)) txq_i (
        .clk(clk), .rst_n(rst_n), .flush(c_reset),
        .push(c_enq && !txq_full), .din(pnr_q), .pop(tx_ok),
        .dout(tx_pkt), .empty(txq_empty), .full(txq_full));

    pba_fifo #(.DEPTH(PKT_NUM), .W(NUM_W)) cq_i (
        .clk(clk), .rst_n(rst_n), .flush(c_reset),
        .push(tx_ok), .din(tx_pkt), .pop(cmpl_pop && !cq_empty),
        .dout(cmpl_pkt), .empty(cq_empty), .full(cq_full));

    pba_fifo #(.DEPTH(PKT_NUM), .W(NUM_W)) rxq_i (
        .clk(clk), .rst_n(rst_n), .flush(c_reset),
        .push(rx_ack), .din(pick_idx), .pop(rel_hit),
        .dout(rx_head), .empty(rx_empty), .full(rxq_full));

    assign tx_req       = !txq_empty;
    assign cmpl_valid   = !cq_empty;
    assign irq_status   = irq_q;
    assign alloc_result = result_q;
    assign free_pages   = free_q;

    // R2: free page count never exceeds the pool
    p_free_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        free_q <= FREE_W'(TOTAL_PAGES));
    // R4: a failure code carries no packet number
    p_fail_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        result_q[7] |-> (result_q[6:0] == 7'd0));
    // R5: a waiting request leaves the result untouched until granted
    p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !alloc_grant) |=> $stable(result_q));
    // R8: completion only follows a queued packet
    p_ack_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ok |=> !cq_empty);
    // R12: reset command empties pool and queues
    p_reset_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        c_reset |=> (free_q == FREE_W'(TOTAL_PAGES) && used_q == '0 && rx_empty && txq_empty));
endmodule

// File: tb/pba_unit_tb.sv
module pba_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [2:0] cmd_arg = 3'd0;
    logic       pnr_wr = 1'b0;
    logic [4:0] pnr_wdata = 5'd0;
    logic [4:0] pnr_q;
    logic [1:0] irq_clr = 2'd0;
    logic [1:0] irq_status;
    logic [7:0] alloc_result;
    logic [6:0] free_pages;
    logic       tx_req, cmpl_valid, rx_ack, rx_empty;
    logic [4:0] tx_pkt, cmpl_pkt, rx_head;
    logic       tx_ack = 1'b0, cmpl_pop = 1'b0, rx_valid = 1'b0;
    logic [2:0] rx_npages = 3'd0;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    pba_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .pnr_wr(pnr_wr), .pnr_wdata(pnr_wdata), .pnr_q(pnr_q),
        .irq_clr(irq_clr), .irq_status(irq_status), .alloc_result(alloc_result),
        .free_pages(free_pages), .tx_req(tx_req), .tx_pkt(tx_pkt), .tx_ack(tx_ack),
        .cmpl_valid(cmpl_valid), .cmpl_pkt(cmpl_pkt), .cmpl_pop(cmpl_pop),
        .rx_valid(rx_valid), .rx_npages(rx_npages), .rx_ack(rx_ack),
        .rx_empty(rx_empty), .rx_head(rx_head));

    // {page count field, expected alloc_result, expected free_pages}
    localparam logic [17:0] VEC [5] = '{
        {3'd0, 8'd0, 7'd63},
        {3'd7, 8'd1, 7'd55},
        {3'd3, 8'd2, 7'd51},
        {3'd1, 8'd3, 7'd49},
        {3'd6, 8'd4, 7'd42}
    };

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [2:0] arg);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; cmd_arg = 3'd0;
    endtask

    task automatic setpnr(input logic [4:0] n);
        @(negedge clk);
        pnr_wr = 1'b1; pnr_wdata = n;
        @(negedge clk);
        pnr_wr = 1'b0;
    endtask

    task automatic irqclr(input logic [1:0] m);
        @(negedge clk);
        irq_clr = m;
        @(negedge clk);
        irq_clr = 2'd0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); tx_ack = 1'b1;
        @(negedge clk); tx_ack = 1'b0;
    endtask

    task automatic pulse_pop();
        @(negedge clk); cmpl_pop = 1'b1;
        @(negedge clk); cmpl_pop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog got=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 free", free_pages, 64);
        chk("R1 irq", irq_status, 0);
        chk("R1 result", alloc_result, 0);
        chk("R1 rx_empty", rx_empty, 1);
        chk("R1 tx_req", tx_req, 0);
        chk("R1 cmpl_valid", cmpl_valid, 0);

        // R2 / R3 table of allocations
        for (int i = 0; i < 5; i++) begin
            cmd(3'd1, VEC[i][17:15]);
            chk("R2 result", alloc_result, VEC[i][14:7]);
            chk("R2 free", free_pages, VEC[i][6:0]);
            chk("R2 irq0", irq_status[0], 1);
            irqclr(2'b01);
            chk("R6 irq clear", irq_status[0], 0);
        end

        // R9 free middle packet, R3 lowest hole reused
        setpnr(5'd1);
        cmd(3'd4, 3'd0);
        chk("R9 free returns pages", free_pages, 50);
        cmd(3'd1, 3'd2);
        chk("R3 lowest free", alloc_result, 1);
        chk("R3 free", free_pages, 47);
        for (int i = 0; i < 5; i++) cmd(3'd1, 3'd7);
        chk("R2 pool low", free_pages, 7);
        irqclr(2'b01);

        // R5 pending allocation
        cmd(3'd1, 3'd7);
        repeat (3) @(negedge clk);
        chk("R5 no irq while pending", irq_status[0], 0);
        chk("R5 result kept", alloc_result, 9);
        setpnr(5'd0);
        cmd(3'd4, 3'd0);
        chk("R9 free one page", free_pages, 8);
        @(negedge clk);
        chk("R5 grant irq", irq_status[0], 1);
        chk("R5 grant number", alloc_result, 0);
        chk("R5 grant free", free_pages, 0);

        // R12 reset then R4 number exhaustion
        cmd(3'd2, 3'd0);
        chk("R12 free", free_pages, 64);
        for (int i = 0; i < 32; i++) cmd(3'd1, 3'd0);
        chk("R3 last number", alloc_result, 31);
        irqclr(2'b01);
        cmd(3'd1, 3'd0);
        chk("R4 fail code", alloc_result, 8'h80);
        chk("R4 irq", irq_status[0], 1);
        chk("R4 free unchanged", free_pages, 32);

        // R9 free of unallocated number has no effect
        cmd(3'd2, 3'd0);
        setpnr(5'd5);
        cmd(3'd4, 3'd0);
        chk("R9 unallocated free", free_pages, 64);

        // R7 / R8 transmit path
        cmd(3'd1, 3'd0);
        cmd(3'd1, 3'd1);
        setpnr(5'd1); cmd(3'd3, 3'd0);
        setpnr(5'd0); cmd(3'd3, 3'd0);
        chk("R7 tx_req", tx_req, 1);
        chk("R7 head", tx_pkt, 1);
        irqclr(2'b11);
        pulse_ack();
        chk("R8 cmpl_valid", cmpl_valid, 1);
        chk("R8 cmpl_pkt", cmpl_pkt, 1);
        chk("R8 irq1", irq_status[1], 1);
        chk("R7 next head", tx_pkt, 0);
        irqclr(2'b10);
        chk("R6 irq1 clear", irq_status[1], 0);
        pulse_ack();
        chk("R8 tx drained", tx_req, 0);
        chk("R8 cmpl order", cmpl_pkt, 1);
        pulse_pop();
        chk("R8 pop", cmpl_pkt, 0);
        pulse_pop();
        chk("R8 cmpl empty", cmpl_valid, 0);

        // R10 / R11 receive path
        cmd(3'd2, 3'd0);
        @(negedge clk);
        rx_valid = 1'b1; rx_npages = 3'd2;
        #1 chk("R10 rx_ack", rx_ack, 1);
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R10 rx_empty", rx_empty, 0);
        chk("R10 rx_head", rx_head, 0);
        chk("R10 free", free_pages, 61);
        cmd(3'd1, 3'd0);
        chk("R3 host after rx", alloc_result, 1);
        @(negedge clk);
        rx_valid = 1'b1; rx_npages = 3'd0;
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R10 second rx free", free_pages, 59);
        cmd(3'd5, 3'd0);
        chk("R11 release free", free_pages, 62);
        chk("R11 new head", rx_head, 2);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_arg = 3'd0;
        rx_valid = 1'b1; rx_npages = 3'd0;
        #1 chk("R10 blocked by alloc", rx_ack, 0);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; rx_valid = 1'b0;
        chk("R3 host gets 0", alloc_result, 0);
        chk("R10 free after alloc", free_pages, 61);
        cmd(3'd5, 3'd0);
        chk("R11 empty after", rx_empty, 1);
        chk("R11 free", free_pages, 62);
        cmd(3'd5, 3'd0);
        chk("R11 release on empty", free_pages, 62);

        // R12 reset clears everything
        setpnr(5'd0); cmd(3'd3, 3'd0);
        cmd(3'd2, 3'd0);
        chk("R12 free all", free_pages, 64);
        chk("R12 tx cleared", tx_req, 0);
        chk("R12 rx cleared", rx_empty, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule